// File: doc/BRIEF.md
# Effective Address Generator with Page-Cross Detect

This unit turns an instruction's addressing mode and operand bytes into a final 16-bit effective address for an 8-bit processor core. A start pulse hands it the mode, the two operand bytes, the X and Y index values, the address of the current opcode and a flag saying whether the opcode pays a cycle penalty on a page cross. Modes that need no memory access finish one cycle after start. Modes that go through a pointer fetch two bytes over a synchronous byte-read port, low byte first, before finishing.

When it finishes, the unit pulses `done` for one cycle. It then holds the address, a page-crossed flag, the penalty flag and an accumulator-mode flag until the next start. The cycle counter of the core uses the penalty flag. The core keeps every input stable from start until `done`.

Mode codes on `mode`: 0 immediate, 1 zero page, 2 zero page + X, 3 zero page + Y, 4 absolute, 5 absolute + X, 6 absolute + Y, 7 indirect, 8 indexed-indirect (X before the pointer), 9 indirect-indexed (Y after the pointer), 10 relative, 11 accumulator. Codes 12 to 15 finish like code 11 but leave `acc_mode` low.

Top module: `ea_gen`

## Requirements
- R1: `done` is high for exactly one cycle per accepted start. It rises one cycle after the start edge for modes 0-6, 10, 11 and 12-15. It rises four cycles after the start edge for modes 7, 8 and 9. A start is accepted only while the unit is idle.
- R2: Mode 1 gives address {0x00, lo}. Modes 2 and 3 give {0x00, (lo + index) mod 256}, so the result stays in page zero.
- R3: Mode 4 gives {hi, lo}. Modes 5 and 6 give {hi, lo} + index. `page_cross` is high exactly when the addition of index and lo carries out of bit 7.
- R4: Mode 7 reads the low byte at pointer P = {hi, lo} and the high byte at {P[15:8], P[7:0] + 1}, so the second read wraps inside the page. Results are little-endian: low byte from the first read.
- R5: Mode 8 forms the zero-page pointer (lo + X) mod 256 and reads two bytes there. The second read address also wraps within page zero.
- R6: Mode 9 reads a pointer from zero page at lo and lo + 1 (mod 256), then adds Y to it. `page_cross` is high exactly when the low byte plus Y carries.
- R7: Mode 10 gives pc + 2 + the sign-extended lo byte.
- R8: Mode 0 gives pc + 1, the address of the byte after the opcode.
- R9: `penalty` equals `page_cross` AND the `penalty_ok` value captured at start.
- R10: Mode 11 raises `acc_mode` with address 0 and no page cross. Every other mode leaves `acc_mode` low.
- R11: After reset `done`, `mem_rd`, `ea`, `page_cross`, `penalty` and `acc_mode` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a calculation (accepted when idle) |
| mode | input | 4 | Addressing mode code |
| opnd_lo | input | 8 | First operand byte |
| opnd_hi | input | 8 | Second operand byte |
| idx_x | input | 8 | X index value |
| idx_y | input | 8 | Y index value |
| pc | input | 16 | Address of the current opcode |
| penalty_ok | input | 1 | Opcode pays an extra cycle on page cross |
| mem_rd | output | 1 | Byte read request |
| mem_addr | output | 16 | Read address |
| mem_rdata | input | 8 | Read data, valid the cycle after the request |
| done | output | 1 | One-cycle pulse: result valid |
| ea | output | 16 | Effective address |
| page_cross | output | 1 | Indexed addition carried out of the low byte |
| penalty | output | 1 | Page cross on a penalty-eligible opcode |
| acc_mode | output | 1 | Accumulator mode, no address |

## Verification
The bench aims at the wrap points. It uses a zero-page base plus index that passes 0xFF, and a pointer at xxFF for indirect and indexed-indirect fetches. A design that carried into the high byte would leave page zero, or would fetch the pointer's high byte from the next page. The memory model returns a byte that depends on both address bytes, so such a fetch changes the result. The bench also runs absolute-indexed and indirect-indexed sums with and without a low-byte carry, each with the penalty flag on and off. This catches a dropped or stuck page-cross report and a penalty that ignores eligibility. Relative offsets of both signs that cross a page check the sign extension, and a measured start-to-done latency catches a fetch sequence with a missing or extra cycle.

// File: rtl/ea_gen.sv
module ea_gen (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [3:0]  mode,
  input  logic [7:0]  opnd_lo,
  input  logic [7:0]  opnd_hi,
  input  logic [7:0]  idx_x,
  input  logic [7:0]  idx_y,
  input  logic [15:0] pc,
  input  logic        penalty_ok,
  output logic        mem_rd,
  output logic [15:0] mem_addr,
  input  logic [7:0]  mem_rdata,
  output logic        done,
  output logic [15:0] ea,
  output logic        page_cross,
  output logic        penalty,
  output logic        acc_mode
);
  localparam logic [3:0] M_IMM = 4'd0, M_ZP = 4'd1, M_ZPX = 4'd2, M_ZPY = 4'd3,
                         M_ABS = 4'd4, M_ABX = 4'd5, M_ABY = 4'd6, M_IND = 4'd7,
                         M_IZX = 4'd8, M_IZY = 4'd9, M_REL = 4'd10, M_ACC = 4'd11;

  typedef enum logic [1:0] {S_IDLE, S_LO, S_HI, S_LAST} st_t;
  st_t st;

  logic [15:0] ptr, d_ea;
  logic [7:0]  lo_q, y_q;
  logic [3:0]  mode_q;
  logic        elig_q, d_pc, is_ind;

  wire [8:0] sum_x = {1'b0, opnd_lo} + {1'b0, idx_x};
  wire [8:0] sum_y = {1'b0, opnd_lo} + {1'b0, idx_y};
  wire [8:0] sum_r = {1'b0, lo_q} + {1'b0, y_q};

  assign mem_rd   = (st == S_LO) || (st == S_HI);
  assign mem_addr = (st == S_HI) ? {ptr[15:8], ptr[7:0] + 8'd1} : ptr;
  assign penalty  = page_cross & elig_q;
  assign is_ind   = (mode == M_IND) || (mode == M_IZX) || (mode == M_IZY);

  always_comb begin
    d_ea = 16'h0000;
    d_pc = 1'b0;
    case (mode)
      M_IMM: d_ea = pc + 16'd1;
      M_ZP:  d_ea = {8'h00, opnd_lo};
      M_ZPX: d_ea = {8'h00, sum_x[7:0]};
      M_ZPY: d_ea = {8'h00, sum_y[7:0]};
      M_ABS: d_ea = {opnd_hi, opnd_lo};
      M_ABX: begin d_ea = {opnd_hi, 8'h00} + {7'b0, sum_x}; d_pc = sum_x[8]; end
      M_ABY: begin d_ea = {opnd_hi, 8'h00} + {7'b0, sum_y}; d_pc = sum_y[8]; end
      M_REL: d_ea = pc + 16'd2 + {{8{opnd_lo[7]}}, opnd_lo};
      default: d_ea = 16'h0000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; ptr <= '0; lo_q <= '0; y_q <= '0; mode_q <= '0; elig_q <= 1'b0;
      done <= 1'b0; ea <= '0; page_cross <= 1'b0; acc_mode <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          mode_q     <= mode;
          y_q        <= idx_y;
          elig_q     <= penalty_ok;
          acc_mode   <= (mode == M_ACC);
          page_cross <= 1'b0;
          if (is_ind) begin
            ptr <= (mode == M_IND) ? {opnd_hi, opnd_lo} :
                   (mode == M_IZX) ? {8'h00, sum_x[7:0]} : {8'h00, opnd_lo};
            st  <= S_LO;
          end else begin
            ea         <= d_ea;
            page_cross <= d_pc;
            done       <= 1'b1;
          end
        end
        S_LO: st <= S_HI;
        S_HI: begin lo_q <= mem_rdata; st <= S_LAST; end
        S_LAST: begin
          if (mode_q == M_IZY) begin
            ea         <= {mem_rdata, 8'h00} + {7'b0, sum_r};
            page_cross <= sum_r[8];
          end else begin
            ea <= {mem_rdata, lo_q};
          end
          done <= 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> !done);
  a_r1_no_read_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_rd);
  a_r4_hi_read_in_page: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd && $past(mem_rd) |->
      mem_addr[15:8] == $past(mem_addr[15:8]) && mem_addr[7:0] == $past(mem_addr[7:0]) + 8'd1);
  a_r5_zp_pointer: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd && (mode_q == M_IZX || mode_q == M_IZY) |-> mem_addr[15:8] == 8'h00);
  a_r2_zp_page: assert property (@(posedge clk) disable iff (!rst_n)
    done && (mode_q == M_ZP || mode_q == M_ZPX || mode_q == M_ZPY) |-> ea[15:8] == 8'h00);
  a_r9_penalty_needs_cross: assert property (@(posedge clk) disable iff (!rst_n)
    penalty |-> page_cross);
  a_r10_acc_no_cross: assert property (@(posedge clk) disable iff (!rst_n)
    done && acc_mode |-> !page_cross && ea == 16'h0000);
endmodule

// File: tb/ea_gen_tb_top.sv
module ea_gen_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, penalty_ok = 1'b0;
  logic [3:0] mode = '0;
  logic [7:0] opnd_lo = '0, opnd_hi = '0, idx_x = '0, idx_y = '0, mem_rdata = '0;
  logic [15:0] pc = '0, mem_addr, ea;
  logic mem_rd, done, page_cross, penalty, acc_mode;
  int checks = 0, fails = 0, cyc = 0;

  typedef struct { logic [15:0] ea; logic pcx; logic pen; logic acc; int lat; int t0; string tag; } item_t;
  item_t sb[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ea_gen dut_i (.clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .opnd_lo(opnd_lo),
    .opnd_hi(opnd_hi), .idx_x(idx_x), .idx_y(idx_y), .pc(pc), .penalty_ok(penalty_ok),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata), .done(done), .ea(ea),
    .page_cross(page_cross), .penalty(penalty), .acc_mode(acc_mode));

  function automatic logic [7:0] memf(logic [15:0] a);
    return (a[7:0] * 8'd3) ^ a[15:8] ^ 8'hA5;
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= memf(mem_addr);

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  always @(negedge clk) if (rst_n && done) begin
    item_t it;
    if (sb.size() == 0) chk(0, "R1 unexpected done", 1, 0);
    else begin
      it = sb.pop_front();
      chk(ea == it.ea, it.tag, ea, it.ea);
      chk(page_cross == it.pcx, "R3/R6 page_cross", page_cross, it.pcx);
      chk(penalty == it.pen, "R9 penalty", penalty, it.pen);
      chk(acc_mode == it.acc, "R10 acc_mode", acc_mode, it.acc);
      chk(cyc - it.t0 == it.lat, "R1 latency", cyc - it.t0, it.lat);
    end
  end

  task automatic drive(logic [3:0] m, logic [7:0] lo, logic [7:0] hi, logic [7:0] x,
                       logic [7:0] y, logic [15:0] p, logic el);
    item_t it;
    logic [8:0] s;
    logic [15:0] ptr, base;
    it.pcx = 1'b0; it.acc = 1'b0; it.lat = 1; it.ea = 16'h0;
    case (m)
      4'd0: begin it.ea = p + 16'd1; it.tag = "R8 immediate"; end
      4'd1: begin it.ea = {8'h00, lo}; it.tag = "R2 zero page"; end
      4'd2: begin it.ea = {8'h00, lo + x}; it.tag = "R2 zero page X"; end
      4'd3: begin it.ea = {8'h00, lo + y}; it.tag = "R2 zero page Y"; end
      4'd4: begin it.ea = {hi, lo}; it.tag = "R3 absolute"; end
      4'd5: begin s = lo + x; it.ea = {hi, lo} + x; it.pcx = s[8]; it.tag = "R3 absolute X"; end
      4'd6: begin s = lo + y; it.ea = {hi, lo} + y; it.pcx = s[8]; it.tag = "R3 absolute Y"; end
      4'd7, 4'd8, 4'd9: begin
        it.lat = 4;
        ptr = (m == 4'd7) ? {hi, lo} : (m == 4'd8) ? {8'h00, lo + x} : {8'h00, lo};
        base = {memf({ptr[15:8], ptr[7:0] + 8'd1}), memf(ptr)};
        if (m == 4'd9) begin
          s = base[7:0] + y; it.ea = base + y; it.pcx = s[8]; it.tag = "R6 post-indexed";
        end else begin
          it.ea = base; it.tag = (m == 4'd7) ? "R4 indirect" : "R5 pre-indexed";
        end
      end
      4'd10: begin it.ea = p + 16'd2 + {{8{lo[7]}}, lo}; it.tag = "R7 relative"; end
      4'd11: begin it.acc = 1'b1; it.tag = "R10 accumulator"; end
      default: it.tag = "R10 unused code";
    endcase
    it.pen = it.pcx & el;
    @(negedge clk);
    mode = m; opnd_lo = lo; opnd_hi = hi; idx_x = x; idx_y = y; pc = p; penalty_ok = el;
    start = 1'b1; it.t0 = cyc; sb.push_back(it);
    @(negedge clk);
    start = 1'b0;
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk({done, mem_rd, page_cross, penalty, acc_mode} == 5'b0, "R11 reset flags",
        {done, mem_rd, page_cross, penalty, acc_mode}, 0);
    chk(ea == 16'h0, "R11 reset ea", ea, 0);
    rst_n = 1'b1;
    @(negedge clk);
    drive(4'd0, 8'h11, 8'h22, 8'h00, 8'h00, 16'h12FF, 1'b0);
    drive(4'd1, 8'h80, 8'h55, 8'h00, 8'h00, 16'h0, 1'b0);
    drive(4'd2, 8'hF0, 8'h55, 8'h20, 8'h00, 16'h0, 1'b1);   // R2 wrap past 0xFF
    drive(4'd3, 8'hFF, 8'h55, 8'h00, 8'h01, 16'h0, 1'b1);
    drive(4'd4, 8'h34, 8'h12, 8'h00, 8'h00, 16'h0, 1'b0);
    drive(4'd5, 8'h10, 8'h20, 8'h05, 8'h00, 16'h0, 1'b1);   // R3 no cross
    drive(4'd5, 8'hF0, 8'h20, 8'h20, 8'h00, 16'h0, 1'b1);   // R3 cross, R9 eligible
    drive(4'd6, 8'hF0, 8'h20, 8'h00, 8'h20, 16'h0, 1'b0);   // R9 not eligible
    drive(4'd6, 8'hFF, 8'hFF, 8'h00, 8'h01, 16'h0, 1'b1);   // top of space
    drive(4'd7, 8'hFF, 8'h12, 8'h00, 8'h00, 16'h0, 1'b0);   // R4 page wrap
    drive(4'd7, 8'h40, 8'h30, 8'h00, 8'h00, 16'h0, 1'b0);
    drive(4'd8, 8'hFE, 8'h00, 8'h01, 8'h00, 16'h0, 1'b0);   // R5 pointer at 0xFF
    drive(4'd8, 8'h10, 8'h00, 8'h05, 8'h00, 16'h0, 1'b0);
    drive(4'd9, 8'hFF, 8'h00, 8'h00, 8'hFF, 16'h0, 1'b1);   // R6 wrap
    drive(4'd9, 8'h20, 8'h00, 8'h00, 8'h00, 16'h0, 1'b1);   // R6 no cross
    drive(4'd10, 8'h7F, 8'h00, 8'h00, 8'h00, 16'h12F0, 1'b0);
    drive(4'd10, 8'h80, 8'h00, 8'h00, 8'h00, 16'h1205, 1'b0);
    drive(4'd11, 8'h33, 8'h44, 8'h55, 8'h66, 16'h7777, 1'b1);
    drive(4'd13, 8'h33, 8'h44, 8'h55, 8'h66, 16'h7777, 1'b1);
    lf = 32'hACE1_2468;
    for (int i = 0; i < 60; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      drive(4'(lf % 12), lf[7:0] ^ lf[23:16], lf[15:8], lf[23:16], lf[31:24], lf[31:16], lf[3]);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule